// File: doc/BRIEF.md
# Converter Serial Port Slave

This block is the digital serial front end of a successive-approximation converter. A host selects it with an active-low select, toggles a serial clock, and exchanges two words. On the way in, the block collects a mode/address word from the serial input. On the way out, it returns the most recent conversion result, MSB first with the sign bit leading. A ready flag stays low for as long as result bits are leaving and goes high once the last bit has gone. All pins are sampled by a fast local clock through two-stage synchronizers, so every serial event takes effect a few local clock cycles after it occurs at the pins.

The captured word goes to the converter core, together with a single-cycle strobe, only when a transfer reaches its full length. The strobe also serves as the request for a new conversion. The block decodes exactly one field of that word: a two-bit length code that sets how many clock pulses the next transfer takes. Everything else in the word is passed through without decoding. When the read-only input is high, the transfer only returns the stored result. If the host keeps select low between transfers, an end-of-conversion pulse from the core starts the next transfer on its own.

Top module: `cvt_serial_slave`

## Requirements
- R1: After reset the output enable is low, the ready flag is high, the committed word is 0 and the transfer length is 13 pulses.
- R2: While a transfer runs, serial input is sampled on each rising serial clock edge. The first 8 samples form the mode word, with the first sample at bit 7. The word appears on `cfgWord` with a one-cycle `cfgStrobe` only when the transfer reaches its full length.
- R3: The output enable is high only while select is low. It drops within 3 local clocks of select going high.
- R4: The select falling edge presents the MSB of the result on the serial output. Each later bit appears on a falling serial clock edge, in order from the most significant bit down.
- R5: Bits [7:6] of a committed word set the length of the following transfers. 00 and 11 give 13 pulses. 01 gives 17 pulses: the 13 result bits followed by 4 zeros. 10 gives 9 pulses: the top 9 result bits.
- R6: The ready flag is low from the first bit until the falling edge after the last rising edge, and high after that edge.
- R7: A transfer that starts with read-only high ignores serial input. It produces no strobe, leaves `cfgWord` unchanged and still shifts out the stored result.
- R8: If read-only and core-busy are both high when select falls, the transfer is refused: the output enable stays low and the ready flag stays high until select rises.
- R9: With select held low after a finished transfer, an end-of-conversion pulse presents the new result's MSB, lowers the ready flag and starts a new full transfer.
- R10: Raising select before the full length is reached aborts the transfer. The ready flag goes high, nothing is committed, and the next transfer starts again from its first bit.
- R11: The result input is stored on every end-of-conversion pulse. A transfer started by a select falling edge returns the latest stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Active-low select |
| serClk | input | 1 | Serial clock from the host |
| serIn | input | 1 | Serial data in (mode word) |
| serOut | output | 1 | Serial data out (result) |
| serOutEn | output | 1 | Drive enable for serOut; low means high impedance |
| outReady | output | 1 | Low while result bits are being shifted |
| readOnly | input | 1 | High selects the read-only transfer |
| coreBusy | input | 1 | Core is converting, calibrating or zeroing |
| convDone | input | 1 | One-cycle end-of-conversion pulse |
| resultIn | input | 13 | Conversion result, sign in bit 12 |
| cfgWord | output | 8 | Last committed mode word |
| cfgStrobe | output | 1 | One-cycle commit and conversion request |

## Verification
Most faults in the bit counter or the transfer state show up at the ports within one serial bit period. A counter that is off by one moves the rising edge of the ready flag by a whole serial clock, and it also changes whether a commit strobe appears at all. If the serial output register shifts in the wrong direction, or loads from the wrong source, the second output bit is already wrong. A broken commit gate shows up after just one read-only or aborted transfer, because `cfgWord` then changes. A length latch that is wrong only shows up one transfer later, so the bench always follows a length-changing word with a transfer of the new length.

// File: rtl/cvt_serial_pkg.sv
package cvt_serial_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_DONE   = 2'd2,
    ST_REFUSE = 2'd3
  } xferState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLatch;   // load output shifter from stored result
    logic loadDirect;  // load output shifter straight from result input
    logic shiftOut;    // advance output shifter by one bit
    logic captureIn;   // shift one synchronized DI sample into mode word
    logic commit;      // publish captured mode word
  } dpStrobe_t;

endpackage

// File: rtl/cvt_serial_ctrl.sv
module cvt_serial_ctrl
  import cvt_serial_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             serClk,
  input  logic             readOnly,
  input  logic             coreBusy,
  input  logic             convDone,
  input  logic [LEN_W-1:0] curLen,
  output dpStrobe_t        strobe,
  output logic             serOutEn,
  output logic             outReady
);

  localparam logic [LEN_W-1:0] CFG_CNT = LEN_W'(CFG_W);

  logic [1:0] csSync, ckSync;
  logic       ckPrev;
  logic       csLow, ckRise, ckFall;

  xferState_t       state, stateNxt;
  logic [LEN_W-1:0] bitCnt, cntNxt;
  logic [LEN_W-1:0] xferLen, lenNxt;
  logic             roLat, roNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= 2'b11;
      ckSync <= 2'b00;
      ckPrev <= 1'b0;
    end else begin
      csSync <= {csSync[0], selN};
      ckSync <= {ckSync[0], serClk};
      ckPrev <= ckSync[1];
    end
  end

  assign csLow  = ~csSync[1];
  assign ckRise = ckSync[1] & ~ckPrev;
  assign ckFall = ~ckSync[1] & ckPrev;

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    lenNxt   = xferLen;
    roNxt    = roLat;
    strobe   = '0;
    if (!csLow) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (readOnly && coreBusy) begin
            stateNxt = ST_REFUSE;
          end else begin
            stateNxt         = ST_SHIFT;
            cntNxt           = '0;
            lenNxt           = curLen;
            roNxt            = readOnly;
            strobe.loadLatch = 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ckRise) begin
            if (bitCnt < xferLen) cntNxt = bitCnt + 1'b1;
            if ((bitCnt < CFG_CNT) && !roLat) strobe.captureIn = 1'b1;
          end else if (ckFall && (bitCnt != '0)) begin
            if (bitCnt == xferLen) begin
              stateNxt      = ST_DONE;
              strobe.commit = ~roLat;
            end else begin
              strobe.shiftOut = 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (convDone) begin
            stateNxt          = ST_SHIFT;
            cntNxt            = '0;
            lenNxt            = curLen;
            roNxt             = readOnly;
            strobe.loadDirect = 1'b1;
          end
        end
        default: stateNxt = ST_REFUSE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      xferLen <= '0;
      roLat   <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= cntNxt;
      xferLen <= lenNxt;
      roLat   <= roNxt;
    end
  end

  assign serOutEn = (state == ST_SHIFT) || (state == ST_DONE);
  assign outReady = (state != ST_SHIFT);

endmodule

// File: rtl/cvt_serial_dpath.sv
module cvt_serial_dpath
  import cvt_serial_pkg::*;
#(
  parameter int RES_W   = 13,
  parameter int CFG_W   = 8,
  parameter int LEN_POS = 6,
  parameter int PAD     = 4,
  parameter int TRIM    = 4,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             convDone,
  input  logic [RES_W-1:0] resultIn,
  input  dpStrobe_t        strobe,
  output logic             serOut,
  output logic [CFG_W-1:0] cfgWord,
  output logic             cfgStrobe,
  output logic [LEN_W-1:0] curLen
);

  localparam int OUT_W = RES_W + PAD;

  logic [1:0]       diSync;
  logic [RES_W-1:0] resLatch;
  logic [OUT_W-1:0] outShift;
  logic [CFG_W-1:0] inShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diSync    <= '0;
      resLatch  <= '0;
      outShift  <= '0;
      inShift   <= '0;
      cfgWord   <= '0;
      cfgStrobe <= 1'b0;
    end else begin
      diSync    <= {diSync[0], serIn};
      cfgStrobe <= strobe.commit;
      if (convDone) resLatch <= resultIn;
      if (strobe.loadDirect) begin
        outShift <= {resultIn, {PAD{1'b0}}};
      end else if (strobe.loadLatch) begin
        outShift <= {resLatch, {PAD{1'b0}}};
      end else if (strobe.shiftOut) begin
        outShift <= {outShift[OUT_W-2:0], 1'b0};
      end
      if (strobe.loadDirect || strobe.loadLatch) begin
        inShift <= '0;
      end else if (strobe.captureIn) begin
        inShift <= {inShift[CFG_W-2:0], diSync[1]};
      end
      if (strobe.commit) cfgWord <= inShift;
    end
  end

  always_comb begin
    unique case (cfgWord[LEN_POS+1:LEN_POS])
      2'b01:   curLen = LEN_W'(RES_W + PAD);
      2'b10:   curLen = LEN_W'(RES_W - TRIM);
      default: curLen = LEN_W'(RES_W);
    endcase
  end

  assign serOut = outShift[OUT_W-1];

endmodule

// File: rtl/cvt_serial_slave.sv
module cvt_serial_slave
  import cvt_serial_pkg::*;
#(
  parameter int RES_W   = 13,
  parameter int CFG_W   = 8,
  parameter int LEN_POS = 6,
  parameter int PAD     = 4,
  parameter int TRIM    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             serClk,
  input  logic             serIn,
  output logic             serOut,
  output logic             serOutEn,
  output logic             outReady,
  input  logic             readOnly,
  input  logic             coreBusy,
  input  logic             convDone,
  input  logic [RES_W-1:0] resultIn,
  output logic [CFG_W-1:0] cfgWord,
  output logic             cfgStrobe
);

  localparam int LEN_W = $clog2(RES_W + PAD + 1);

  dpStrobe_t        strobe;
  logic [LEN_W-1:0] curLen;

  cvt_serial_ctrl #(.CFG_W(CFG_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk),
    .readOnly(readOnly), .coreBusy(coreBusy), .convDone(convDone),
    .curLen(curLen), .strobe(strobe), .serOutEn(serOutEn), .outReady(outReady)
  );

  cvt_serial_dpath #(.RES_W(RES_W), .CFG_W(CFG_W), .LEN_POS(LEN_POS),
                     .PAD(PAD), .TRIM(TRIM), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .serIn(serIn), .convDone(convDone),
    .resultIn(resultIn), .strobe(strobe), .serOut(serOut),
    .cfgWord(cfgWord), .cfgStrobe(cfgStrobe), .curLen(curLen)
  );

endmodule

// File: rtl/cvt_serial_slave_chk.sv
module cvt_serial_slave_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             selN,
  input logic             serOutEn,
  input logic             outReady,
  input logic             cfgStrobe,
  input logic [CFG_W-1:0] cfgWord
);

  AST_BUSY_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> serOutEn);  // R6

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selN, 1) && $past(selN, 2) && $past(selN, 3)) |-> !serOutEn);  // R3

  AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> (outReady && $past(!outReady)));  // R2

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |=> !cfgStrobe);  // R2

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgWord) |-> cfgStrobe);  // R7

endmodule

bind cvt_serial_slave cvt_serial_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .serOutEn(serOutEn),
  .outReady(outReady), .cfgStrobe(cfgStrobe), .cfgWord(cfgWord)
);

// File: tb/cvt_serial_slave_bench.sv
module cvt_serial_slave_bench;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selN = 1'b1;
  logic        serClk = 1'b0;
  logic        serIn = 1'b0;
  logic        readOnly = 1'b0;
  logic        coreBusy = 1'b0;
  logic        convDone = 1'b0;
  logic [12:0] resultIn = '0;
  logic        serOut, serOutEn, outReady, cfgStrobe;
  logic [7:0]  cfgWord;

  int checks = 0;
  int failures = 0;
  int strobeCnt = 0;

  always #2.5 clk = ~clk;

  cvt_serial_slave u_cvt_serial_slave (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk), .serIn(serIn),
    .serOut(serOut), .serOutEn(serOutEn), .outReady(outReady),
    .readOnly(readOnly), .coreBusy(coreBusy), .convDone(convDone),
    .resultIn(resultIn), .cfgWord(cfgWord), .cfgStrobe(cfgStrobe)
  );

  always @(posedge clk) if (cfgStrobe) strobeCnt <= strobeCnt + 1;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [12:0] r, input int i);
    return (i < 13) ? r[12-i] : 1'b0;
  endfunction

  task automatic pulseDone(input logic [12:0] v);
    resultIn = v;
    convDone = 1'b1;
    wclk(1);
    convDone = 1'b0;
  endtask

  // Assumes the first bit has just been launched; checks every bit and DOR
  task automatic shiftWord(input logic [12:0] res, input int len, input logic [7:0] mode);
    wclk(HALF);
    chk("R3 enable in data phase", serOutEn, 1);
    chk("R6 ready low in data phase", outReady, 0);
    chk("R4 first bit", serOut, expBit(res, 0));
    for (int i = 0; i < len; i++) begin
      serIn  = (i < 8) ? mode[7-i] : 1'b0;
      serClk = 1'b1;
      wclk(HALF);
      if (i == len - 1) chk("R6 ready low before last fall", outReady, 0);
      serClk = 1'b0;
      wclk(HALF);
      if (i < len - 1) chk($sformatf("R4 R5 bit %0d", i + 1), serOut, expBit(res, i + 1));
      else             chk("R6 ready high after last fall", outReady, 1);
    end
  endtask

  task automatic selLow();
    selN = 1'b0;
  endtask

  task automatic selHigh();
    selN = 1'b1;
    wclk(HALF);
    chk("R3 enable off after deselect", serOutEn, 0);
  endtask

  task automatic tReset();
    chk("R1 enable", serOutEn, 0);
    chk("R1 ready", outReady, 1);
    chk("R1 word", cfgWord, 0);
    chk("R1 strobe", strobeCnt, 0);
  endtask

  task automatic tBasic();
    int s0;
    pulseDone(13'h1A5B);
    wclk(2);
    s0 = strobeCnt;
    selLow();
    shiftWord(13'h1A5B, 13, 8'h2D);
    chk("R2 strobe count", strobeCnt - s0, 1);
    chk("R2 word", cfgWord, 8'h2D);
    selHigh();
    pulseDone(13'h0F31);
    wclk(2);
    selLow();
    shiftWord(13'h0F31, 13, 8'h00);
    chk("R11 word", cfgWord, 8'h00);
    selHigh();
  endtask

  task automatic tLength();
    selLow(); shiftWord(13'h0F31, 13, 8'h4C); selHigh();
    chk("R5 word", cfgWord, 8'h4C);
    selLow(); shiftWord(13'h0F31, 17, 8'h8C); selHigh();
    selLow(); shiftWord(13'h0F31, 9, 8'hC3); selHigh();
    selLow(); shiftWord(13'h0F31, 13, 8'h00); selHigh();
    chk("R5 word restored", cfgWord, 8'h00);
  endtask

  task automatic tReadOnly();
    int s0 = strobeCnt;
    readOnly = 1'b1;
    selLow();
    shiftWord(13'h0F31, 13, 8'hFF);
    selHigh();
    readOnly = 1'b0;
    chk("R7 no strobe", strobeCnt - s0, 0);
    chk("R7 word kept", cfgWord, 8'h00);
  endtask

  task automatic tRefuse();
    readOnly = 1'b1;
    coreBusy = 1'b1;
    selLow();
    wclk(HALF);
    chk("R8 enable off", serOutEn, 0);
    for (int i = 0; i < 13; i++) begin
      serClk = 1'b1; wclk(HALF);
      serClk = 1'b0; wclk(HALF);
    end
    chk("R8 enable still off", serOutEn, 0);
    chk("R8 ready high", outReady, 1);
    selHigh();
    readOnly = 1'b0;
    coreBusy = 1'b0;
  endtask

  task automatic tContinuous();
    selLow();
    shiftWord(13'h0F31, 13, 8'h11);
    wclk(HALF);
    chk("R9 ready idle between", outReady, 1);
    pulseDone(13'h1C07);
    shiftWord(13'h1C07, 13, 8'h22);
    chk("R9 second word", cfgWord, 8'h22);
    selHigh();
  endtask

  task automatic tAbort();
    int s0 = strobeCnt;
    selLow();
    wclk(HALF);
    for (int i = 0; i < 5; i++) begin
      serIn = 1'b1;
      serClk = 1'b1; wclk(HALF);
      serClk = 1'b0; wclk(HALF);
    end
    selN = 1'b1;
    wclk(HALF);
    chk("R10 ready after abort", outReady, 1);
    chk("R10 no strobe", strobeCnt - s0, 0);
    chk("R10 word kept", cfgWord, 8'h22);
    selLow();
    shiftWord(13'h1C07, 13, 8'h05);
    chk("R10 fresh transfer commits", cfgWord, 8'h05);
    selHigh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wclk(4);
    rstN = 1'b1;
    wclk(4);
    tReset();
    tBasic();
    tLength();
    tReadOnly();
    tRefuse();
    tContinuous();
    tAbort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule